// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder with Run-Time Generators

This block recovers the message bits of a rate 1/2, constraint-length-3 convolutional code. Each message bit was sent as a pair of hard-decision coded bits. The two 3-tap generator polynomials are not fixed in the hardware. They are sampled together with the frame length when a frame starts. From them the block builds and stores its expected-output table for the four trellis states. The state-transition relation is fixed by the shift structure, so it is wired rather than stored.

During a frame, the block takes one symbol pair per accepted input cycle. For every state it computes Hamming branch metrics and adds them to the accumulated error metrics. An add-compare-select step keeps one survivor per state and records a one-bit decision per state and step in a survivor buffer. After the last symbol, traceback starts from the state whose metric is smallest. It writes the decoded bits into a small buffer, and the bits then leave in time order with a valid strobe. A one-cycle done pulse closes the frame.

Top module: `vit_dec_top`

## Requirements
- R1: After reset, `busy`, `done` and `bit_valid` are all low.
- R2: A `start` pulse while `busy` is low samples `gen_a`, `gen_b` and `frame_len`. The legal range of `frame_len` is 1 to MAX_LEN. The pulse raises `busy` on the next cycle and restarts the metrics, with state 0 at metric 0 and all other states at the saturated maximum. Changes to `start`, `gen_a`, `gen_b` or `frame_len` while `busy` is high have no effect on the frame.
- R3: The symbol convention is as follows. The encoder starts in state 0. The state index is {previous bit, bit before it}. For message bit u, `sym[1]` is the parity of `gen_a & {u, previous bit, bit before it}`, and `sym[0]` is the same parity using `gen_b`. A symbol is taken only in a cycle where `sym_valid` is high during reception.
- R4: An error-free frame decodes exactly for each of the generator pairs {111,101}, {111,110} and {110,101}.
- R5: When the transmitted bits carry one or two errors, the output is the unique message whose coded sequence lies nearest to the received one. This includes message 1110 with generators 111/101, 100110 with 111/110 and 110101 with 110/101, each followed by two zero flush bits.
- R6: Traceback starts from the state with the lowest final metric. On an equal final metric the lower-numbered state wins. Within add-compare-select, the path from the lower-numbered predecessor is kept on a tie.
- R7: After the last symbol the block emits exactly `frame_len` `bit_valid` pulses, carrying the message bits in time order. `done` then pulses for one cycle, and in that same cycle `busy` is low.
- R8: Frames of length 1 and MAX_LEN decode correctly.
- R9: `sym_valid` while the block is idle has no effect on the next frame.
- R10: Accumulated metrics saturate at their maximum instead of wrapping. The smallest metric never decreases within a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken while idle) |
| gen_a | input | 3 | Generator for `sym[1]`; bit 2 taps the current bit |
| gen_b | input | 3 | Generator for `sym[0]`; bit 2 taps the current bit |
| frame_len | input | LW | Message bits (symbol pairs) in the frame |
| sym_valid | input | 1 | `sym` holds a symbol pair |
| sym | input | 2 | Hard-decision coded pair |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| bit_valid | output | 1 | `bit_out` holds a decoded bit |
| bit_out | output | 1 | Decoded message bit |

## Verification
Every 6-bit message is sent without errors under each of the three generator pairs. This separates a correct table derivation and symbol bit order from a swapped or miswired one. Some of these frames have gaps in `sym_valid`, stray `start` pulses, or idle symbol traffic, to show that these are ignored.

The three named messages, with flush bits, are then sent with every single-bit and every two-bit error pattern. Each pattern is checked whenever a brute-force nearest-codeword search in the bench finds a unique answer. This separates a true minimum-metric survivor choice from a reversed compare or wrapping metrics.

Two deliberately tied cases pin down the lowest-state rule at traceback. Lengths 1 and 64 exercise the buffer ends.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int MEM = 2;            // encoder memory
  localparam int GW  = MEM + 1;      // generator taps
  localparam int NST = 1 << MEM;     // trellis states

  typedef logic [1:0] sym_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_FIND, PH_TB_RD, PH_TB_USE, PH_OUT, PH_FIN
  } phase_t;

  function automatic logic [1:0] hd2(input sym_t v);
    return {1'b0, v[1]} + {1'b0, v[0]};
  endfunction
endpackage

// File: rtl/vit_tables.sv
module vit_tables
  import vit_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [GW-1:0]             gen_a,
  input  logic [GW-1:0]             gen_b,
  output logic [NST*2-1:0][1:0]     out_tbl
);
  logic [NST*2-1:0][1:0] tbl_c;

  // entry index = state*2 + input bit; window = {input bit, state}
  for (genvar s = 0; s < NST; s++) begin : g_st
    for (genvar u = 0; u < 2; u++) begin : g_in
      localparam int WINI = u * NST + s;
      localparam logic [GW-1:0] WIN = WINI[GW-1:0];
      assign tbl_c[s*2+u] = {^(gen_a & WIN), ^(gen_b & WIN)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       out_tbl <= '0;
    else if (load) out_tbl <= tbl_c;
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init,
  input  logic                  en,
  input  sym_t                  sym,
  input  logic [NST*2-1:0][1:0] out_tbl,
  output logic [NST-1:0]        dec,
  output logic [MW-1:0]         min_val,
  output logic [MEM-1:0]        min_idx
);
  localparam logic [MW-1:0] MMAX = {MW{1'b1}};

  logic [NST-1:0][MW-1:0] metric, nxt_m, init_m;

  // next state = {u, s[MEM-1]}: predecessors of ns are {ns[0], x}, u = ns[1]
  for (genvar ns = 0; ns < NST; ns++) begin : g_acs
    localparam int U  = ns / (NST / 2);
    localparam int P0 = (ns % (NST / 2)) * 2;
    localparam int P1 = P0 + 1;
    logic [1:0]    bm0, bm1;
    logic [MW:0]   s0, s1;
    logic [MW-1:0] c0, c1;
    assign bm0 = hd2(sym ^ out_tbl[P0*2+U]);
    assign bm1 = hd2(sym ^ out_tbl[P1*2+U]);
    assign s0  = {1'b0, metric[P0]} + {{(MW-1){1'b0}}, bm0};
    assign s1  = {1'b0, metric[P1]} + {{(MW-1){1'b0}}, bm1};
    assign c0  = s0[MW] ? MMAX : s0[MW-1:0];
    assign c1  = s1[MW] ? MMAX : s1[MW-1:0];
    assign dec[ns]   = (c1 < c0);          // tie keeps lower predecessor
    assign nxt_m[ns] = dec[ns] ? c1 : c0;
    assign init_m[ns] = (ns == 0) ? '0 : MMAX;
  end

  always_ff @(posedge clk) begin
    if (rst || init) metric <= init_m;
    else if (en)     metric <= nxt_m;
  end

  always_comb begin
    min_val = metric[0];
    min_idx = '0;
    for (int i = 1; i < NST; i++) begin
      if (metric[i] < min_val) begin
        min_val = metric[i];
        min_idx = MEM'(i);
      end
    end
  end
endmodule

// File: rtl/vit_surv_ram.sv
module vit_surv_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vit_dec_top.sv
module vit_dec_top
  import vit_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int MW      = 6,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    gen_a,
  input  logic [2:0]    gen_b,
  input  logic [LW-1:0] frame_len,
  input  logic          sym_valid,
  input  logic [1:0]    sym,
  output logic          busy,
  output logic          done,
  output logic          bit_valid,
  output logic          bit_out
);
  localparam int AW = $clog2(MAX_LEN);

  phase_t                ph;
  logic [LW-1:0]         flen_q;
  logic [AW-1:0]         step, tb_idx, oidx, last_idx;
  logic [MEM-1:0]        tb_st;
  logic [MAX_LEN-1:0]    dbuf;
  logic                  acs_init, acs_en;
  logic [NST*2-1:0][1:0] out_tbl;
  logic [NST-1:0]        dec, surv_rd;
  logic [MW-1:0]         acs_min;
  logic [MEM-1:0]        acs_min_idx;
  logic [LW-1:0]         flen_m1;

  assign acs_init = (ph == PH_IDLE) && start;
  assign acs_en   = (ph == PH_RX) && sym_valid;
  assign flen_m1  = flen_q - 1'b1;
  assign last_idx = flen_m1[AW-1:0];

  vit_tables u_tbl (
    .clk(clk), .rst(rst), .load(acs_init),
    .gen_a(gen_a), .gen_b(gen_b), .out_tbl(out_tbl)
  );

  vit_acs #(.MW(MW)) u_acs (
    .clk(clk), .rst(rst), .init(acs_init), .en(acs_en), .sym(sym),
    .out_tbl(out_tbl), .dec(dec), .min_val(acs_min), .min_idx(acs_min_idx)
  );

  vit_surv_ram #(.DEPTH(MAX_LEN), .W(NST), .AW(AW)) u_surv (
    .clk(clk), .we(acs_en), .waddr(step), .wdata(dec),
    .raddr(tb_idx), .rdata(surv_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      flen_q    <= '0;
      step      <= '0;
      tb_idx    <= '0;
      oidx      <= '0;
      tb_st     <= '0;
      dbuf      <= '0;
    end else begin
      done      <= 1'b0;
      bit_valid <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          flen_q <= frame_len;
          step   <= '0;
          busy   <= 1'b1;
          ph     <= PH_RX;
        end
        PH_RX: if (sym_valid) begin
          step <= step + 1'b1;
          if (step == last_idx) ph <= PH_FIND;
        end
        PH_FIND: begin
          tb_st  <= acs_min_idx;
          tb_idx <= last_idx;
          ph     <= PH_TB_RD;
        end
        PH_TB_RD: ph <= PH_TB_USE;
        PH_TB_USE: begin
          dbuf[tb_idx] <= tb_st[MEM-1];
          tb_st        <= {tb_st[0], surv_rd[tb_st]};
          if (tb_idx == '0) begin
            oidx <= '0;
            ph   <= PH_OUT;
          end else begin
            tb_idx <= tb_idx - 1'b1;
            ph     <= PH_TB_RD;
          end
        end
        PH_OUT: begin
          bit_valid <= 1'b1;
          bit_out   <= dbuf[oidx];
          oidx      <= oidx + 1'b1;
          if (oidx == last_idx) ph <= PH_FIN;
        end
        PH_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          ph   <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vit_dec_chk.sv
module vit_dec_chk #(
  parameter int LW = 7,
  parameter int MW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          bit_valid,
  input logic [LW-1:0] frame_len,
  input logic          acs_en,
  input logic [MW-1:0] acs_min
);
  logic [LW-1:0] cnt, flen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flen <= '0;
    end else if (start && !busy) begin
      cnt  <= '0;
      flen <= frame_len;
    end else if (bit_valid) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt == flen);                                    // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                          // R7
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> busy);                                      // R7
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                    // R7
  AST_START_RESETS_METRIC: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> acs_min == '0);                      // R2
  AST_MIN_NONDECREASING: assert property (@(posedge clk) disable iff (rst)
    acs_en |=> acs_min >= $past(acs_min));                    // R10
endmodule

bind vit_dec_top vit_dec_chk #(.LW(LW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .bit_valid(bit_valid), .frame_len(frame_len),
  .acs_en(acs_en), .acs_min(acs_min)
);

// File: tb/sim_vit_dec_top.sv
module sim_vit_dec_top;
  localparam int MAX_LEN = 64;
  localparam int LW = $clog2(MAX_LEN + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sym_valid = 1'b0;
  logic [2:0] gen_a = '0, gen_b = '0;
  logic [LW-1:0] frame_len = '0;
  logic [1:0] sym = '0;
  logic busy, done, bit_valid, bit_out;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  vit_dec_top #(.MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst(rst), .start(start), .gen_a(gen_a), .gen_b(gen_b),
    .frame_len(frame_len), .sym_valid(sym_valid), .sym(sym),
    .busy(busy), .done(done), .bit_valid(bit_valid), .bit_out(bit_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // R3 convention: sym[1] from ga, sym[0] from gb, window {u, b1, b2}
  function automatic logic [127:0] enc(input logic [2:0] ga, input logic [2:0] gb,
                                       input logic [63:0] msg, input int n);
    logic b1 = 1'b0, b2 = 1'b0;
    logic [127:0] r = '0;
    for (int t = 0; t < n; t++) begin
      r[2*t+1] = ^(ga & {msg[t], b1, b2});
      r[2*t]   = ^(gb & {msg[t], b1, b2});
      b2 = b1;
      b1 = msg[t];
    end
    return r;
  endfunction

  task automatic run_frame(input logic [2:0] ga, input logic [2:0] gb, input int n,
                           input logic [127:0] rx, input bit gaps, input bit poke,
                           output logic [63:0] got, output int nb);
    int guard = 0;
    start = 1'b1; gen_a = ga; gen_b = gb; frame_len = LW'(n);
    @(negedge clk);
    start = 1'b0; gen_a = 3'b000; gen_b = 3'b000; frame_len = LW'(1);
    chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    for (int t = 0; t < n; t++) begin
      if (gaps && (t % 3 == 1)) begin
        sym_valid = 1'b0; sym = ~rx[2*t +: 2];
        @(negedge clk);
      end
      sym_valid = 1'b1; sym = rx[2*t +: 2];
      if (poke && t == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    sym_valid = 1'b0;
    got = '0; nb = 0;
    while (!done && guard < 1000) begin
      if (bit_valid) begin
        got[nb] = bit_out;
        nb++;
      end
      @(negedge clk);
      guard++;
    end
    chk(guard < 1000 && busy === 1'b0, "R7 done with busy low", 64'(busy), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single cycle", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] msk(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 1);
  endfunction

  logic [2:0] pga [3] = '{3'b111, 3'b111, 3'b110};
  logic [2:0] pgb [3] = '{3'b101, 3'b110, 3'b101};
  logic [63:0] pmsg [3] = '{64'd7, 64'd25, 64'd43};   // 1110, 100110, 110101 in time order
  int          pn   [3] = '{6, 8, 8};                  // includes two flush zeros

  initial begin
    logic [63:0] got, msg, best;
    logic [127:0] tx, rx;
    int nb, d, dmin, nmin;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && bit_valid === 0, "R1 reset state",
        {61'd0, busy, done, bit_valid}, 64'd0);

    // R4/R3/R9/R2: all 6-bit messages, three generator pairs
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 64; m++) begin
        if (m % 5 == 0) begin            // R9 idle symbol traffic
          sym_valid = 1'b1; sym = 2'(m);
          repeat (3) @(negedge clk);
          sym_valid = 1'b0;
        end
        tx = enc(pga[p], pgb[p], 64'(m), 6);
        run_frame(pga[p], pgb[p], 6, tx, (m % 4 == 0), (m % 8 == 3), got, nb);
        chk(got == 64'(m) && nb == 6, "R4 error-free decode", got, 64'(m));
      end
    end

    // R8 length boundaries
    for (int b = 0; b < 2; b++) begin
      run_frame(3'b111, 3'b101, 1, enc(3'b111, 3'b101, 64'(b), 1), 0, 0, got, nb);
      chk(got == 64'(b) && nb == 1, "R8 length 1", got, 64'(b));
    end
    msg = 64'hC3A5_0F96_1E2D_7B48;
    run_frame(3'b110, 3'b101, 64, enc(3'b110, 3'b101, msg, 64), 1, 0, got, nb);
    chk(got == msg && nb == 64, "R8 length max", got, msg);

    // R6 final tie: received 11 01 10 00, states 1 and 3 tie at metric 1
    rx = enc(3'b111, 3'b101, 64'd7, 4) ^ (128'd1 << 6);
    run_frame(3'b111, 3'b101, 4, rx, 0, 0, got, nb);
    chk(got == 64'd7, "R6 tie lowest state", got, 64'd7);
    run_frame(3'b111, 3'b101, 1, 128'b01, 0, 0, got, nb);
    chk(got == 64'd0, "R6 tie length 1", got, 64'd0);

    // R5: every single and double error, compared to brute-force nearest codeword
    for (int p = 0; p < 3; p++) begin
      tx = enc(pga[p], pgb[p], pmsg[p], pn[p]);
      for (int e1 = 0; e1 < 2 * pn[p]; e1++) begin
        for (int e2 = e1; e2 < 2 * pn[p]; e2++) begin
          rx = tx ^ (128'd1 << e1) ^ ((e2 != e1) ? (128'd1 << e2) : 128'd0);
          dmin = 1000; nmin = 0; best = '0;
          for (int c = 0; c < (1 << pn[p]); c++) begin
            d = $countones(enc(pga[p], pgb[p], 64'(c), pn[p]) ^ rx);
            if (d < dmin) begin dmin = d; nmin = 1; best = 64'(c); end
            else if (d == dmin) nmin++;
          end
          if (nmin == 1) begin
            run_frame(pga[p], pgb[p], pn[p], rx, 0, 0, got, nb);
            chk((got & msk(pn[p])) == best, "R5 nearest codeword", got, best);
          end
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule